// File: doc/BRIEF.md
# Iterative Recursive Adder With Completion Flag

This block adds two unsigned W-bit operands (32 by default). It is a clocked model of a self-timed recursive adder. A start pulse captures the operands and opens a one-cycle select phase. In that phase every bit slice reads the captured operand bits. After it, every bit slice reads the partial sum and the carry vector fed back from the previous step.

On each clock every position forms a half-add: the new partial sum is the XOR of the two selected bits, and the new carry is their AND. The carry vector moves up one place before it is fed back. A carry leaving the top bit is kept as the carry-out. Carry chains that do not touch each other advance in the same cycles, so the latency depends on the longest chain and not on the word width. The block raises an active-high completion flag once no carry remains anywhere. The flag is blocked during the select phase, and it marks sum and carry-out as valid.

Top module: `iter_adder`

## Requirements
- R1: A synchronous active-high reset drives sum to 0, carry_out to 0 and term to 0. The outputs keep these values until a start is seen.
- R2: opa and opb are sampled only on a clock edge where start is 1. Changing them at any other time has no effect on sum, carry_out or term.
- R3: In the cycle that follows a start edge (the select phase), term is 0.
- R4: While term is 1, {carry_out, sum} equals the 33-bit sum opa + opb of the operands captured at the last start.
- R5: If the operands share no set bit, term rises one clock edge after the select phase, which is the second edge counted from the start edge.
- R6: term rises no later than W clock edges after the start edge. All-ones plus one takes exactly W edges and gives sum 0 and carry_out 1.
- R7: Once term is 1, term, sum and carry_out stay unchanged until the next start.
- R8: A start given while an addition is still running abandons that addition and begins a new one with the newly sampled operands.
- R9: Disjoint carry chains advance together. The latency in edges counted from the start edge is 1 plus the length of the longest chain: 2^k-1 plus 1 takes k+1 edges for k < W, and two such chains in separate halves of the word take the same time as one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the operands and opens the select phase |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| sum | output | W | Partial sum; the final sum while term is 1 |
| carry_out | output | 1 | Carry out of the top bit; final while term is 1 |
| term | output | 1 | Completion flag, high while the result is valid |

## Verification
The embedded properties assume that reset is asserted before the first start. They also assume that start and the operands are driven to clean 0/1 values, and that the operands are meaningful only on the start edge. The bench keeps to this. It changes inputs only on the falling clock edge and holds start for exactly one cycle per addition. It scrambles the operands while a run is in progress, which shows that no stray sampling takes place. The bench measures latency in clock edges counted from the start edge. It compares this count against the chain lengths of hand-picked operands, and it applies the W bound to random ones.

// File: rtl/iter_adder.sv
module iter_adder #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         term
);
  localparam int CW = $clog2(W + 1) + 1;

  logic [W-1:0] a_q, b_q;
  logic [W-1:0] x_q, y_q;
  logic         sel, loaded, cout_q;

  logic [W-1:0] u, v, s_n, g;

  for (genvar i = 0; i < W; i++) begin : g_slice
    assign u[i]   = sel ? a_q[i] : x_q[i];
    assign v[i]   = sel ? b_q[i] : y_q[i];
    assign s_n[i] = u[i] ^ v[i];
    assign g[i]   = u[i] & v[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      sel    <= 1'b0;
      loaded <= 1'b0;
      cout_q <= 1'b0;
    end else if (start) begin
      a_q    <= opa;
      b_q    <= opb;
      sel    <= 1'b1;
      loaded <= 1'b1;
      cout_q <= 1'b0;
    end else begin
      x_q <= s_n;
      y_q <= {g[W-2:0], 1'b0};
      sel <= 1'b0;
      if (g[W-1]) cout_q <= 1'b1;
    end
  end

  assign sum       = x_q;
  assign carry_out = cout_q;
  assign term      = loaded & ~sel & ~(|y_q);

  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= '0;
    else if (cnt < CW'(W)) cnt <= cnt + 1'b1;
  end

  a_r3_no_term_in_select: assert property (@(posedge clk) disable iff (rst)
    sel |-> !term);

  a_r2_start_opens_select: assert property (@(posedge clk) disable iff (rst)
    start |=> (sel && !term));

  a_r8_select_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (sel && !start) |=> !sel);

  a_r6_latency_bound: assert property (@(posedge clk) disable iff (rst)
    (loaded && !sel && cnt >= CW'(W)) |-> term);

  a_r4_result_matches: assert property (@(posedge clk) disable iff (rst)
    term |-> ({carry_out, sum} == ({1'b0, a_q} + {1'b0, b_q})));

  a_r7_result_holds: assert property (@(posedge clk) disable iff (rst)
    (term && !start) |=> (term && $stable(sum) && $stable(carry_out)));
endmodule

// File: tb/iter_adder_bench.sv
`timescale 1ns/1ps
module iter_adder_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] sum;
  logic         carry_out, term;

  int total = 0;
  int bad = 0;

  iter_adder #(.W(W)) u_iter_adder (
    .clk(clk), .rst(rst), .start(start), .opa(opa), .opb(opb),
    .sum(sum), .carry_out(carry_out), .term(term)
  );

  always #2 clk = ~clk;

  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h1234_5678, 32'h8765_4321},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h8000_0000},
    {32'hAAAA_AAAA, 32'h5555_5555},
    {32'hDEAD_BEEF, 32'h0BAD_F00D},
    {32'hFFFF_0000, 32'h0001_0000},
    {32'h0F0F_F0F0, 32'h3C3C_C3C3}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!term && lat < W + 4) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string tag, output int lat);
    logic [W:0] ref_v;
    ref_v = {1'b0, a} + {1'b0, b};
    launch(a, b);
    chk(term == 1'b0, {"R3 select phase ", tag}, 64'(term), 64'd0);
    wait_done(lat);
    chk({carry_out, sum} == ref_v, {"R4 result ", tag}, 64'({carry_out, sum}), 64'(ref_v));
    chk(lat <= W, {"R6 latency bound ", tag}, 64'(lat), 64'(W));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [W-1:0] held;
    bit ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({sum, carry_out, term} == '0, "R1 reset state", 64'({sum, carry_out, term}), 64'd0);
    opa = 32'hFFFF_FFFF; opb = 32'h1;
    repeat (3) @(negedge clk);
    chk(term == 1'b0 && sum == '0, "R1 idle without start", 64'({sum, term}), 64'd0);

    for (int i = 0; i < 8; i++) begin
      run(VEC[i][63:32], VEC[i][31:0], "table", lat);
    end

    for (int i = 0; i < 40; i++) begin
      run($urandom, $urandom, "random", lat);
    end

    run(32'hAAAA_AAAA, 32'h5555_5555, "no carry", lat);
    chk(lat == 1, "R5 no-carry latency", 64'(lat), 64'd1);

    run(32'h0000_1234, 32'h0000_0000, "zero operand", lat);
    chk(lat == 1, "R5 zero operand latency", 64'(lat), 64'd1);

    run(32'hFFFF_FFFF, 32'h1, "all ones plus one", lat);
    chk(lat == W, "R6 worst case latency", 64'(lat), 64'(W));
    chk(sum == '0 && carry_out == 1'b1, "R6 worst case result", 64'({carry_out, sum}), 64'h1_0000_0000);

    run(32'h0000_000F, 32'h1, "chain 4", lat);
    chk(lat == 5, "R9 single chain latency", 64'(lat), 64'd5);

    run(32'h000F_000F, 32'h0001_0001, "two chains", lat);
    chk(lat == 5, "R9 parallel chains latency", 64'(lat), 64'd5);

    run(32'h7FFF_FFFF, 32'h1, "chain 31", lat);
    chk(lat == 32, "R9 long chain latency", 64'(lat), 64'd32);

    launch(32'hFFFF_FFFF, 32'h1);
    opa = 32'h1357_9BDF; opb = 32'h2468_ACE0;
    @(negedge clk);
    opa = 32'hFFFF_FFFF; opb = 32'hFFFF_FFFF;
    wait_done(lat);
    chk(sum == '0 && carry_out == 1'b1, "R2 operands ignored while running",
        64'({carry_out, sum}), 64'h1_0000_0000);

    held = sum;
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      opa = $urandom; opb = $urandom;
      @(negedge clk);
      if (!(term && sum == held && carry_out)) ok = 1'b0;
    end
    chk(ok, "R7 result held until next start", 64'({term, carry_out, sum}), 64'({2'b11, held}));

    launch(32'hFFFF_FFFF, 32'h1);
    repeat (3) @(negedge clk);
    launch(32'h5, 32'h3);
    chk(term == 1'b0, "R8 restart enters select phase", 64'(term), 64'd0);
    wait_done(lat);
    chk(term && sum == 32'h8 && carry_out == 1'b0, "R8 restart result",
        64'({term, carry_out, sum}), 64'h2_0000_0008);

    launch(32'hFFFF_FFFF, 32'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({sum, carry_out, term} == '0, "R1 reset mid-run", 64'({sum, carry_out, term}), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule